// File: doc/BRIEF.md
# Partition-Label Register Access Decoder

This block classifies one move-to or move-from system register instruction that may name the partition-labelling register, either through its own encoding or through the encoding that a host hypervisor uses to reach the guest copy. It is purely combinational. It takes the instruction's encoding fields, the current exception level, the implemented and enabled levels, the trap controls, the host-extension bit, the three nested-virtualization bits and the debug state. From these it returns a single verdict for the execution pipeline.

There are six possible verdicts. The encoding may not belong to this register. The access may be undefined. It may trap to level 2 or level 3 with a fixed syndrome class. It may be redirected to a memory slot at a fixed offset. It may go to the register itself, or it may be steered to the level-2 register that the encoding aliases under host extension. The checks follow a strict priority order, and that order is different for each encoding and each level. The read/write direction of the instruction is passed through with every matched verdict so the consumer can issue the access.

Top module: `sysreg_trap_decode`

## Requirements
- R1: An encoding that matches neither op0=3, op1=0, CRn=10, CRm=5, op2=0 (primary) nor the same fields with op1=5 (alias) yields act_o=0 (none), with tgt_el_o, ec_o, nv_off_o and wr_o all zero.
- R2: Either encoding issued at level 0 yields act_o=1 (undefined).
- R3: Primary encoding at level 1: when level 3 is implemented and trap_lower_i is set, the result is undefined if halted_i and sdd_i are both 1, and otherwise act_o=2 (trap) with tgt_el_o=3. This check takes priority over all others.
- R4: Primary encoding at level 1, R3 not applying: when level 2 is enabled and trap_reg_i is set, act_o=2 with tgt_el_o=2.
- R5: Primary encoding at level 1, R3 and R4 not applying: when level 2 is enabled and nv_i ({NV2,NV1,NV}) equals 3'b111, act_o=3 (memory redirect). Otherwise act_o=4 (local register).
- R6: Primary encoding at level 2: the R3 trap-lower check, including its halted exception, applies first. Then e2h_i=1 gives act_o=5 (level-2 alias register), and e2h_i=0 gives act_o=4.
- R7: Primary encoding at level 3 always gives act_o=4.
- R8: Alias encoding at level 1: level 2 enabled with nv_i=3'b101 gives act_o=3. Otherwise, level 2 enabled with nv_i[0]=1 traps (act_o=2), with tgt_el_o=3 when level 3 is implemented and trap_lower_i is set and tgt_el_o=2 otherwise; the halted state is not considered. Every other case is undefined.
- R9: Alias encoding at level 2: undefined when e2h_i=0. Otherwise the R3 trap-lower check with its halted exception applies, and then act_o=4.
- R10: Alias encoding at level 3 gives act_o=4 only when level 2 is enabled, el2_aarch32_i=0 and e2h_i=1. Every other case is undefined.
- R11: ec_o is 6'h18 exactly when act_o=2 and zero otherwise. nv_off_o is 12'h900 exactly when act_o=3 and zero otherwise. tgt_el_o is zero unless act_o=2. wr_o equals wr_i whenever act_o is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op0_i | input | 2 | Encoding field op0 |
| op1_i | input | 3 | Encoding field op1 |
| crn_i | input | 4 | Encoding field CRn |
| crm_i | input | 4 | Encoding field CRm |
| op2_i | input | 3 | Encoding field op2 |
| wr_i | input | 1 | 1 for a move-to (write), 0 for a move-from (read) |
| cur_el_i | input | 2 | Current exception level |
| el3_impl_i | input | 1 | Level 3 implemented |
| el2_en_i | input | 1 | Level 2 present and enabled |
| el2_aarch32_i | input | 1 | Level 2 runs in 32-bit mode |
| trap_lower_i | input | 1 | Level-3 trap-lower control |
| trap_reg_i | input | 1 | Level-2 trap control for this register |
| e2h_i | input | 1 | Host-extension bit |
| nv_i | input | 3 | Nested-virtualization bits {NV2,NV1,NV} |
| halted_i | input | 1 | Core in debug halt |
| sdd_i | input | 1 | Secure debug disabled |
| act_o | output | 3 | Verdict: 0 none, 1 undefined, 2 trap, 3 memory redirect, 4 local, 5 alias |
| tgt_el_o | output | 2 | Trap target level |
| ec_o | output | 6 | Syndrome exception class |
| nv_off_o | output | 12 | Redirect memory offset |
| wr_o | output | 1 | Direction of the matched access |

## Verification
The bench builds the decoder with its default parameters. These are the two encodings above, syndrome class 0x18 and redirect offset 0x900, so every verdict in the requirements can be reached. With these values the control inputs, the level, the direction and all eight op1 values form a space of 2^17 points, and the bench walks all of it against a behavioural model. The walk therefore covers every priority collision, such as trap-lower against halted with secure debug disabled, or nested-virtualization redirect against the register trap. Separate passes corrupt op0, CRn, CRm and op2 in turn to confirm that near-miss encodings are rejected.

// File: rtl/sysreg_trap_pkg.sv
package sysreg_trap_pkg;
  typedef enum logic [2:0] {
    ACT_NONE  = 3'd0,
    ACT_UNDEF = 3'd1,
    ACT_TRAP  = 3'd2,
    ACT_NVMEM = 3'd3,
    ACT_LOCAL = 3'd4,
    ACT_ALIAS = 3'd5
  } act_e;

  typedef struct packed {
    act_e       act;
    logic [1:0] tgt;
  } verdict_t;

  localparam logic [2:0] NV_REDIR_PRI = 3'b111;
  localparam logic [2:0] NV_REDIR_ALT = 3'b101;
endpackage

// File: rtl/sysreg_enc_match.sv
module sysreg_enc_match #(
  parameter logic [1:0] OP0     = 2'b11,
  parameter logic [2:0] PRI_OP1 = 3'b000,
  parameter logic [2:0] ALT_OP1 = 3'b101,
  parameter logic [3:0] CRN     = 4'b1010,
  parameter logic [3:0] CRM     = 4'b0101,
  parameter logic [2:0] OP2     = 3'b000
) (
  input  logic [1:0] op0_i,
  input  logic [2:0] op1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] op2_i,
  output logic       hit_pri_o,
  output logic       hit_alt_o
);
  logic common;
  assign common    = (op0_i == OP0) && (crn_i == CRN) && (crm_i == CRM) && (op2_i == OP2);
  assign hit_pri_o = common && (op1_i == PRI_OP1);
  assign hit_alt_o = common && (op1_i == ALT_OP1) && !(op1_i == PRI_OP1);
endmodule

// File: rtl/sysreg_tl_gate.sv
module sysreg_tl_gate (
  input  logic el3_impl_i,
  input  logic trap_lower_i,
  input  logic halted_i,
  input  logic sdd_i,
  output logic tl_on_o,
  output logic tl_undef_o
);
  assign tl_on_o    = el3_impl_i && trap_lower_i;
  // halted with secure debug disabled turns the top-level trap into undefined
  assign tl_undef_o = tl_on_o && halted_i && sdd_i;
endmodule

// File: rtl/sysreg_pri_path.sv
module sysreg_pri_path
  import sysreg_trap_pkg::*;
(
  input  logic [1:0] cur_el_i,
  input  logic       el2_en_i,
  input  logic       trap_reg_i,
  input  logic       e2h_i,
  input  logic [2:0] nv_i,
  input  logic       tl_on_i,
  input  logic       tl_undef_i,
  output verdict_t   v_o
);
  always_comb begin
    v_o.act = ACT_UNDEF;
    v_o.tgt = 2'd0;
    unique case (cur_el_i)
      2'd1: begin
        if (tl_on_i) begin
          if (tl_undef_i) v_o.act = ACT_UNDEF;
          else begin v_o.act = ACT_TRAP; v_o.tgt = 2'd3; end
        end else if (el2_en_i && trap_reg_i) begin
          v_o.act = ACT_TRAP; v_o.tgt = 2'd2;
        end else if (el2_en_i && (nv_i == NV_REDIR_PRI)) begin
          v_o.act = ACT_NVMEM;
        end else begin
          v_o.act = ACT_LOCAL;
        end
      end
      2'd2: begin
        if (tl_on_i) begin
          if (tl_undef_i) v_o.act = ACT_UNDEF;
          else begin v_o.act = ACT_TRAP; v_o.tgt = 2'd3; end
        end else if (e2h_i) v_o.act = ACT_ALIAS;
        else                v_o.act = ACT_LOCAL;
      end
      2'd3:    v_o.act = ACT_LOCAL;
      default: v_o.act = ACT_UNDEF;
    endcase
  end
endmodule

// File: rtl/sysreg_alt_path.sv
module sysreg_alt_path
  import sysreg_trap_pkg::*;
(
  input  logic [1:0] cur_el_i,
  input  logic       el2_en_i,
  input  logic       el2_aarch32_i,
  input  logic       e2h_i,
  input  logic [2:0] nv_i,
  input  logic       tl_on_i,
  input  logic       tl_undef_i,
  output verdict_t   v_o
);
  always_comb begin
    v_o.act = ACT_UNDEF;
    v_o.tgt = 2'd0;
    unique case (cur_el_i)
      2'd1: begin
        if (el2_en_i && (nv_i == NV_REDIR_ALT)) begin
          v_o.act = ACT_NVMEM;
        end else if (el2_en_i && nv_i[0]) begin
          // no halted exception on this path
          v_o.act = ACT_TRAP;
          v_o.tgt = tl_on_i ? 2'd3 : 2'd2;
        end
      end
      2'd2: begin
        if (e2h_i) begin
          if (tl_on_i) begin
            if (!tl_undef_i) begin v_o.act = ACT_TRAP; v_o.tgt = 2'd3; end
          end else v_o.act = ACT_LOCAL;
        end
      end
      2'd3: begin
        if (el2_en_i && !el2_aarch32_i && e2h_i) v_o.act = ACT_LOCAL;
      end
      default: v_o.act = ACT_UNDEF;
    endcase
  end
endmodule

// File: rtl/sysreg_trap_decode.sv
module sysreg_trap_decode
  import sysreg_trap_pkg::*;
#(
  parameter logic [1:0] OP0     = 2'b11,
  parameter logic [2:0] PRI_OP1 = 3'b000,
  parameter logic [2:0] ALT_OP1 = 3'b101,
  parameter logic [3:0] CRN     = 4'b1010,
  parameter logic [3:0] CRM     = 4'b0101,
  parameter logic [2:0] OP2     = 3'b000,
  parameter int         EC_W    = 6,
  parameter logic [EC_W-1:0] TRAP_EC = 6'h18,
  parameter int         OFF_W   = 12,
  parameter logic [OFF_W-1:0] NV_OFF = 12'h900
) (
  input  logic [1:0]       op0_i,
  input  logic [2:0]       op1_i,
  input  logic [3:0]       crn_i,
  input  logic [3:0]       crm_i,
  input  logic [2:0]       op2_i,
  input  logic             wr_i,
  input  logic [1:0]       cur_el_i,
  input  logic             el3_impl_i,
  input  logic             el2_en_i,
  input  logic             el2_aarch32_i,
  input  logic             trap_lower_i,
  input  logic             trap_reg_i,
  input  logic             e2h_i,
  input  logic [2:0]       nv_i,
  input  logic             halted_i,
  input  logic             sdd_i,
  output logic [2:0]       act_o,
  output logic [1:0]       tgt_el_o,
  output logic [EC_W-1:0]  ec_o,
  output logic [OFF_W-1:0] nv_off_o,
  output logic             wr_o
);
  logic     hit_pri, hit_alt, tl_on, tl_undef;
  verdict_t v_pri, v_alt, v_sel;

  sysreg_enc_match #(
    .OP0(OP0), .PRI_OP1(PRI_OP1), .ALT_OP1(ALT_OP1),
    .CRN(CRN), .CRM(CRM), .OP2(OP2)
  ) u_match (
    .op0_i(op0_i), .op1_i(op1_i), .crn_i(crn_i), .crm_i(crm_i), .op2_i(op2_i),
    .hit_pri_o(hit_pri), .hit_alt_o(hit_alt)
  );

  sysreg_tl_gate u_gate (
    .el3_impl_i(el3_impl_i), .trap_lower_i(trap_lower_i),
    .halted_i(halted_i), .sdd_i(sdd_i),
    .tl_on_o(tl_on), .tl_undef_o(tl_undef)
  );

  sysreg_pri_path u_pri (
    .cur_el_i(cur_el_i), .el2_en_i(el2_en_i), .trap_reg_i(trap_reg_i),
    .e2h_i(e2h_i), .nv_i(nv_i), .tl_on_i(tl_on), .tl_undef_i(tl_undef),
    .v_o(v_pri)
  );

  sysreg_alt_path u_alt (
    .cur_el_i(cur_el_i), .el2_en_i(el2_en_i), .el2_aarch32_i(el2_aarch32_i),
    .e2h_i(e2h_i), .nv_i(nv_i), .tl_on_i(tl_on), .tl_undef_i(tl_undef),
    .v_o(v_alt)
  );

  always_comb begin
    v_sel.act = ACT_NONE;
    v_sel.tgt = 2'd0;
    if (hit_pri)      v_sel = v_pri;
    else if (hit_alt) v_sel = v_alt;
  end

  assign act_o    = v_sel.act;
  assign tgt_el_o = (v_sel.act == ACT_TRAP) ? v_sel.tgt : 2'd0;
  assign ec_o     = (v_sel.act == ACT_TRAP) ? TRAP_EC : '0;
  assign nv_off_o = (v_sel.act == ACT_NVMEM) ? NV_OFF : '0;
  assign wr_o     = (v_sel.act != ACT_NONE) && wr_i;

  always_comb begin
    if (!hit_pri && !hit_alt)
      assert_no_hit_none_R1: assert (act_o == 3'd0 && wr_o == 1'b0);
    if ((hit_pri || hit_alt) && cur_el_i == 2'd0)
      assert_el0_undef_R2: assert (act_o == 3'd1);
    if (hit_pri && cur_el_i == 2'd1 && el3_impl_i && trap_lower_i && !(halted_i && sdd_i))
      assert_pri_tl_trap_R3: assert (act_o == 3'd2 && tgt_el_o == 2'd3);
    if (hit_pri && cur_el_i == 2'd3)
      assert_pri_el3_local_R7: assert (act_o == 3'd4);
    if (hit_alt && cur_el_i == 2'd3 && !el2_en_i)
      assert_alt_el3_undef_R10: assert (act_o == 3'd1);
    if (act_o == 3'd2)
      assert_trap_target_R11: assert (tgt_el_o == 2'd2 || tgt_el_o == 2'd3);
  end
endmodule

// File: tb/sysreg_trap_decode_bench.sv
module sysreg_trap_decode_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]  op0;
  logic [2:0]  op1, op2, nv;
  logic [3:0]  crn, crm;
  logic        wr, el3, el2, a32, tl, tr, e2h, hlt, sdd;
  logic [1:0]  el;
  logic [2:0]  act;
  logic [1:0]  tgt;
  logic [5:0]  ec;
  logic [11:0] off;
  logic        wro;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  sysreg_trap_decode u_sysreg_trap_decode (
    .op0_i(op0), .op1_i(op1), .crn_i(crn), .crm_i(crm), .op2_i(op2),
    .wr_i(wr), .cur_el_i(el), .el3_impl_i(el3), .el2_en_i(el2),
    .el2_aarch32_i(a32), .trap_lower_i(tl), .trap_reg_i(tr), .e2h_i(e2h),
    .nv_i(nv), .halted_i(hlt), .sdd_i(sdd),
    .act_o(act), .tgt_el_o(tgt), .ec_o(ec), .nv_off_o(off), .wr_o(wro)
  );

  // behavioural reference: returns action code and target level, plus the requirement tag
  task automatic model(output int a, output int t, output string tag);
    bit pri, alt, tl_on, tl_und;
    pri = (op0 == 2'd3) && (crn == 4'd10) && (crm == 4'd5) && (op2 == 3'd0) && (op1 == 3'd0);
    alt = (op0 == 2'd3) && (crn == 4'd10) && (crm == 4'd5) && (op2 == 3'd0) && (op1 == 3'd5);
    tl_on  = el3 && tl;
    tl_und = tl_on && hlt && sdd;
    a = 0; t = 0; tag = "R1";
    if (!pri && !alt) return;
    if (el == 0) begin a = 1; tag = "R2"; return; end
    if (pri) begin
      if (el == 1) begin
        if (tl_on) begin tag = "R3"; if (tl_und) a = 1; else begin a = 2; t = 3; end end
        else if (el2 && tr) begin tag = "R4"; a = 2; t = 2; end
        else begin tag = "R5"; a = (el2 && nv == 3'b111) ? 3 : 4; end
      end else if (el == 2) begin
        tag = "R6";
        if (tl_on) begin if (tl_und) a = 1; else begin a = 2; t = 3; end end
        else a = e2h ? 5 : 4;
      end else begin tag = "R7"; a = 4; end
    end else begin
      if (el == 1) begin
        tag = "R8";
        if (el2 && nv == 3'b101) a = 3;
        else if (el2 && nv[0]) begin a = 2; t = tl_on ? 3 : 2; end
        else a = 1;
      end else if (el == 2) begin
        tag = "R9";
        if (!e2h) a = 1;
        else if (tl_on) begin if (tl_und) a = 1; else begin a = 2; t = 3; end end
        else a = 4;
      end else begin tag = "R10"; a = (el2 && !a32 && e2h) ? 4 : 1; end
    end
  endtask

  task automatic compare();
    int a, t;
    string tag;
    int ex_ec, ex_off, ex_wr;
    model(a, t, tag);
    ex_ec  = (a == 2) ? 'h18 : 0;
    ex_off = (a == 3) ? 'h900 : 0;
    ex_wr  = (a != 0) ? int'(wr) : 0;
    checks++;
    if (int'(act) != a || int'(tgt) != t) begin
      errors++;
      $display("FAIL %s: act=%0d tgt=%0d expected act=%0d tgt=%0d (el=%0d op1=%0d nv=%b)",
               tag, act, tgt, a, t, el, op1, nv);
    end
    checks++;
    if (int'(ec) != ex_ec || int'(off) != ex_off || int'(wro) != ex_wr) begin
      errors++; // R11 side outputs
      $display("FAIL R11: ec=%0h off=%0h wr=%0d expected ec=%0h off=%0h wr=%0d",
               ec, off, wro, ex_ec, ex_off, ex_wr);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    @(posedge clk);
    #1;
  endtask

  initial begin
    op0 = '0; op1 = '0; op2 = '0; crn = '0; crm = '0; nv = '0; wr = 0; el = 0;
    el3 = 0; el2 = 0; a32 = 0; tl = 0; tr = 0; e2h = 0; hlt = 0; sdd = 0;
    @(posedge clk); #1;
    step(); // idle state: all-zero encoding gives no verdict (R1)

    crn = 4'd10; crm = 4'd5; op2 = 3'd0; op0 = 2'd3;
    // exhaustive walk of op1, level, controls, nv and direction (R2..R11)
    for (int i = 0; i < 131072; i++) begin
      op1 = i[2:0];
      el  = i[4:3];
      el3 = i[5]; el2 = i[6]; a32 = i[7]; tl = i[8];
      tr  = i[9]; e2h = i[10]; hlt = i[11]; sdd = i[12];
      nv  = i[15:13];
      wr  = i[16];
      step();
    end

    // near-miss encodings must not match (R1)
    for (int k = 0; k < 64; k++) begin
      op0 = 2'd3; op1 = k[0] ? 3'd5 : 3'd0; crn = 4'd10; crm = 4'd5; op2 = 3'd0;
      el = 2'd3; el2 = 1; e2h = 1; a32 = 0; wr = 1;
      unique case (k[2:1])
        2'd0: op0 = 2'(k[4:3]) == 2'd3 ? 2'd1 : 2'(k[4:3]);
        2'd1: crn = 4'd10 ^ {1'b0, k[5:3]} ^ 4'd8;
        2'd2: crm = 4'd5 ^ {k[5:3], 1'b1};
        default: op2 = 3'(k[5:3]) == 3'd0 ? 3'd7 : 3'(k[5:3]);
      endcase
      step();
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !done) begin
        errors++;
        $display("FAIL watchdog: cycles=%0d expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end
endmodule